// File: doc/BRIEF.md
# Instruction Decode Class Dispatcher

This block stands between a queue of instructions whose lengths are already known and three decode paths: a short path that can take two instructions at once, a long path, and a vector path for complex work. Each clock it looks at the one or two entries at the head of the queue. Each entry carries a byte length and a complex flag. The block sorts each entry into a class and forms one legal dispatch group. A group is two short instructions, or one long instruction, or one vector instruction.

The chosen group is loaded into a registered output stage, which uses a valid/ready handshake toward the decoders. On the queue side the block reports a pop count of 0, 1 or 2. A non-zero count means the queue must drop that many head entries at the coming clock edge. The block never reads raw instruction bytes. It uses only the length and the flag that come with each entry. Dispatch follows program order, so the head entry always goes first and no entry is ever skipped.

Top module: `dcd_dispatch`

## Requirements
- R1: A present entry whose length is 1 to 7 and whose complex flag is low is sent on the short path (path code 1).
- R2: A present entry whose length is 8 to 11 and whose complex flag is low is sent on the long path (path code 2).
- R3: A present entry whose complex flag is high is sent on the vector path (path code 3), whatever its length.
- R4: A present entry longer than 11 bytes whose complex flag is low is sent on the vector path (path code 3).
- R5: When both head entries are short, both are dispatched together with a pop count of 2. Slot 0 carries the head entry and slot 1 carries the second entry, each with its own length.
- R6: When the head entry is short and the second entry is long, vector, not valid or of length 0, only the head is dispatched. The pop count is 1 and slot 1 reads path code 0 with length 0.
- R7: A long or vector head is always dispatched alone, with a pop count of 1 and slot 1 at path code 0, even when the second entry is short.
- R8: When the head entry is not valid or has length 0, nothing is dispatched and the pop count is 0, whatever the second entry holds.
- R9: While the output is valid and the output ready input is low, the output valid, path codes and lengths hold their values and the pop count is 0.
- R10: A high synchronous reset clears the output valid at the next clock edge and holds the pop count at 0 while it is high.
- R11: The pop count is non-zero only when the output stage is empty or being drained that cycle. The group it describes appears on the outputs with output valid high after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_vld | input | 2 | Valid of queue entries; bit 0 is the head, bit 1 the second entry |
| q_len | input | 2*LEN_W | Byte lengths; bits [LEN_W-1:0] belong to the head |
| q_cplx | input | 2 | Complex flag of each queue entry |
| in_pop | output | 2 | Number of head entries the queue removes at this edge |
| out_valid | output | 1 | A dispatch group is offered to the decoders |
| out_ready | input | 1 | Decoders accept the offered group |
| out_path0 | output | 2 | Path code of slot 0: 0 none, 1 short, 2 long, 3 vector |
| out_path1 | output | 2 | Path code of slot 1: 0 none or 1 short |
| out_len0 | output | LEN_W | Byte length carried with slot 0 |
| out_len1 | output | LEN_W | Byte length carried with slot 1, 0 when the slot is empty |

## Verification
The assertions assume that the queue lowers an entry's valid bit whenever it has no instruction there. They also assume that the queue treats the pop count as binding at the next edge, so the two head entries shift in program order. The stimulus drives the inputs only between clock edges, with reset high from time zero. It holds out_ready low for runs of several cycles so that backpressure happens while both entries are short and ready to pair. It also asserts reset while a group is still waiting at the output.

// File: rtl/dcd_disp_pkg.sv
package dcd_disp_pkg;

  typedef enum logic [1:0] {
    PATH_NONE   = 2'd0,
    PATH_SHORT  = 2'd1,
    PATH_LONG   = 2'd2,
    PATH_VECTOR = 2'd3
  } path_e;

  // Class of one queue entry; an absent or lengthless entry has no path.
  function automatic path_e class_of(input logic present, input int unsigned len,
                                     input logic cplx, input int unsigned short_max,
                                     input int unsigned long_max);
    path_e res;
    if (!present || len == 0) res = PATH_NONE;
    else if (cplx)            res = PATH_VECTOR;
    else if (len <= short_max) res = PATH_SHORT;
    else if (len <= long_max)  res = PATH_LONG;
    else                       res = PATH_VECTOR;
    return res;
  endfunction

  // Number of entries a group consumes.
  function automatic logic [1:0] group_size(input logic lead, input logic pair);
    return pair ? 2'd2 : (lead ? 2'd1 : 2'd0);
  endfunction

endpackage

// File: rtl/dcd_slot_classify.sv
module dcd_slot_classify
  import dcd_disp_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int SHORT_MAX = 7,
  parameter int LONG_MAX  = 11
) (
  input  logic             vld,
  input  logic [LEN_W-1:0] len,
  input  logic             cplx,
  output path_e            path
);

  always_comb begin
    path = class_of(vld, 32'(len), cplx, SHORT_MAX, LONG_MAX);
  end

endmodule

// File: rtl/dcd_group_select.sv
module dcd_group_select
  import dcd_disp_pkg::*;
(
  input  path_e      lead_path,
  input  path_e      next_path,
  input  logic       accept,
  output logic       take_pair,
  output logic [1:0] pop
);

  logic lead_ok;

  always_comb begin
    lead_ok   = (lead_path != PATH_NONE);
    take_pair = (lead_path == PATH_SHORT) && (next_path == PATH_SHORT);
    pop       = accept ? group_size(lead_ok, take_pair) : 2'd0;
    assert_pop_bound_R11: assert (pop != 2'd3);
  end

endmodule

// File: rtl/dcd_out_stage.sv
module dcd_out_stage
  import dcd_disp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  path_e            d_path0,
  input  path_e            d_path1,
  input  logic [LEN_W-1:0] d_len0,
  input  logic [LEN_W-1:0] d_len1,
  input  logic             out_ready,
  output logic             free,
  output logic             out_valid,
  output path_e            out_path0,
  output path_e            out_path1,
  output logic [LEN_W-1:0] out_len0,
  output logic [LEN_W-1:0] out_len1
);

  logic drain;

  always_comb begin
    drain = out_valid && out_ready;
    free  = !out_valid || out_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_path0 <= PATH_NONE;
      out_path1 <= PATH_NONE;
      out_len0  <= '0;
      out_len1  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_path0 <= d_path0;
      out_path1 <= d_path1;
      out_len0  <= d_len0;
      out_len1  <= d_len1;
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_path0) && $stable(out_path1)
                                   && $stable(out_len0) && $stable(out_len1)));

  assert_no_load_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !load);

  assert_reset_clear_R10: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

// File: rtl/dcd_dispatch.sv
module dcd_dispatch
  import dcd_disp_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int SHORT_MAX = 7,
  parameter int LONG_MAX  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         q_vld,
  input  logic [2*LEN_W-1:0] q_len,
  input  logic [1:0]         q_cplx,
  output logic [1:0]         in_pop,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_path0,
  output logic [1:0]         out_path1,
  output logic [LEN_W-1:0]   out_len0,
  output logic [LEN_W-1:0]   out_len1
);

  localparam int SLOTS = 2;
  localparam logic [LEN_W-1:0] LONG_TOP  = LEN_W'(LONG_MAX);
  localparam logic [LEN_W-1:0] SHORT_TOP = LEN_W'(SHORT_MAX);

  path_e            slot_path [SLOTS];
  logic [LEN_W-1:0] slot_len  [SLOTS];
  logic             take_pair;
  logic             stage_free;
  logic             accept;
  logic             load;
  path_e            next_path1;
  logic [LEN_W-1:0] next_len1;
  path_e            o_path0;
  path_e            o_path1;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_len[g] = q_len[g*LEN_W +: LEN_W];
    dcd_slot_classify #(
      .LEN_W(LEN_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)
    ) u_cls (
      .vld  (q_vld[g]),
      .len  (slot_len[g]),
      .cplx (q_cplx[g]),
      .path (slot_path[g])
    );
  end

  always_comb begin
    accept     = stage_free && !rst;
    load       = (in_pop != 2'd0);
    next_path1 = take_pair ? slot_path[1] : PATH_NONE;
    next_len1  = take_pair ? slot_len[1] : '0;
  end

  dcd_group_select u_sel (
    .lead_path (slot_path[0]),
    .next_path (slot_path[1]),
    .accept    (accept),
    .take_pair (take_pair),
    .pop       (in_pop)
  );

  dcd_out_stage #(.LEN_W(LEN_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .d_path0   (slot_path[0]),
    .d_path1   (next_path1),
    .d_len0    (slot_len[0]),
    .d_len1    (next_len1),
    .out_ready (out_ready),
    .free      (stage_free),
    .out_valid (out_valid),
    .out_path0 (o_path0),
    .out_path1 (o_path1),
    .out_len0  (out_len0),
    .out_len1  (out_len1)
  );

  assign out_path0 = o_path0;
  assign out_path1 = o_path1;

  assert_short_len_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && o_path0 == PATH_SHORT) |-> (out_len0 != '0 && out_len0 <= SHORT_TOP));

  assert_long_len_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && o_path0 == PATH_LONG) |-> (out_len0 > SHORT_TOP && out_len0 <= LONG_TOP));

  assert_cplx_vector_R3: assert property (@(posedge clk) disable iff (rst)
    (in_pop != 2'd0 && q_cplx[0]) |=> (o_path0 == PATH_VECTOR));

  assert_overlong_vector_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len0 > LONG_TOP) |-> (o_path0 == PATH_VECTOR));

  assert_pair_result_R5: assert property (@(posedge clk) disable iff (rst)
    (in_pop == 2'd2) |=> (out_valid && o_path0 == PATH_SHORT && o_path1 == PATH_SHORT));

  assert_single_result_R6: assert property (@(posedge clk) disable iff (rst)
    (in_pop == 2'd1) |=> (out_valid && o_path1 == PATH_NONE && out_len1 == '0));

  assert_no_mixed_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && o_path0 != PATH_SHORT) |-> (o_path1 == PATH_NONE));

  assert_blocked_head_R8: assert property (@(posedge clk) disable iff (rst)
    (!q_vld[0] || slot_len[0] == '0) |-> (in_pop == 2'd0));

  assert_pop_when_free_R11: assert property (@(posedge clk) disable iff (rst)
    (in_pop != 2'd0) |-> (!out_valid || out_ready));

  assert_pop_loads_R11: assert property (@(posedge clk) disable iff (rst)
    (in_pop != 2'd0) |=> out_valid);

endmodule

// File: tb/dcd_dispatch_tb.sv
module dcd_dispatch_tb;

  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    q_vld = '0;
  logic [2*LW-1:0] q_len = '0;
  logic [1:0]    q_cplx = '0;
  logic [1:0]    in_pop;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_path0, out_path1;
  logic [LW-1:0] out_len0, out_len1;

  int n_chk = 0;
  int n_bad = 0;
  bit mdl_full = 1'b0;

  typedef struct packed {
    logic [1:0]    p0;
    logic [1:0]    p1;
    logic [LW-1:0] l0;
    logic [LW-1:0] l1;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dcd_dispatch #(.LEN_W(LW)) u_dut (
    .clk(clk), .rst(rst), .q_vld(q_vld), .q_len(q_len), .q_cplx(q_cplx),
    .in_pop(in_pop), .out_valid(out_valid), .out_ready(out_ready),
    .out_path0(out_path0), .out_path1(out_path1),
    .out_len0(out_len0), .out_len1(out_len1)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Bench view of the classes: 0 none, 1 short, 2 long, 3 vector.
  function automatic int code_for(input bit v, input int len, input bit c);
    if (!v || len < 1) return 0;
    if (c) return 3;
    if (len > 11) return 3;
    return (len >= 8) ? 2 : 1;
  endfunction

  // One cycle of stimulus; checks the pop count and queues the expected group.
  task automatic step(input string req, input bit v0, input int l0, input bit c0,
                      input bit v1, input int l1, input bit c1, input bit rdy);
    int  k0, k1, want;
    bit  room, nxt;
    item_t it;
    q_vld  = {v1, v0};
    q_len  = {LW'(l1), LW'(l0)};
    q_cplx = {c1, c0};
    out_ready = rdy;
    #1;
    k0   = code_for(v0, l0, c0);
    k1   = code_for(v1, l1, c1);
    room = !mdl_full || rdy;
    want = 0;
    if (room && k0 != 0) want = (k0 == 1 && k1 == 1) ? 2 : 1;
    check({req, " pop"}, int'(in_pop), want);
    if (want != 0) begin
      it.p0 = 2'(k0);
      it.l0 = LW'(l0);
      it.p1 = (want == 2) ? 2'd1 : 2'd0;
      it.l1 = (want == 2) ? LW'(l1) : '0;
      exp_q.push_back(it);
      tag_q.push_back(req);
    end
    nxt = (want != 0) ? 1'b1 : (mdl_full && !rdy);
    @(posedge clk);
    #1 mdl_full = nxt;
    #1;
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    q_vld = 2'b11; q_len = {LW'(2), LW'(3)}; q_cplx = '0;
    @(posedge clk);
    #1 mdl_full = 1'b0;
    #1;
    check({req, " pop held in reset"}, int'(in_pop), 0);
    check({req, " valid cleared"}, int'(out_valid), 0);
    @(posedge clk);
    #2 rst = 1'b0;
  endtask

  // Monitor: compares the offered group against the scoreboard mid-cycle.
  always @(negedge clk) begin
    if (!rst) begin
      check("R11 out_valid", int'(out_valid), int'(mdl_full));
      if (out_valid && exp_q.size() > 0) begin
        check({tag_q[0], " path0"}, int'(out_path0), int'(exp_q[0].p0));
        check({tag_q[0], " path1"}, int'(out_path1), int'(exp_q[0].p1));
        check({tag_q[0], " len0"},  int'(out_len0),  int'(exp_q[0].l0));
        check({tag_q[0], " len1"},  int'(out_len1),  int'(exp_q[0].l1));
        if (out_ready) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (out_valid) begin
        check("R11 unexpected group", 1, 0);
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    check("R10 reset valid", int'(out_valid), 0);
    check("R10 reset pop", int'(in_pop), 0);
    @(posedge clk); @(posedge clk);
    #2 rst = 1'b0;

    step("R5 R1 short pair",        1, 3, 0, 1, 5, 0, 1);
    step("R5 R1 pair bounds",       1, 1, 0, 1, 7, 0, 1);
    step("R6 R1 short then long",   1, 7, 0, 1, 8, 0, 1);
    step("R7 R2 long head",         1, 8, 0, 1, 2, 0, 1);
    step("R2 long upper bound",     1, 11, 0, 1, 4, 0, 1);
    step("R4 overlong vector",      1, 12, 0, 1, 3, 0, 1);
    step("R4 R7 max length",        1, 15, 0, 1, 15, 0, 1);
    step("R3 R7 complex short len", 1, 2, 1, 1, 2, 0, 1);
    step("R3 complex long len",     1, 15, 1, 0, 0, 0, 1);
    step("R6 short then complex",   1, 4, 0, 1, 3, 1, 1);
    step("R8 lengthless head",      1, 0, 0, 1, 3, 0, 1);
    step("R8 invalid head",         0, 5, 0, 1, 3, 0, 1);
    step("R6 second lengthless",    1, 6, 0, 1, 0, 0, 1);
    step("R6 second invalid",       1, 2, 0, 0, 4, 0, 1);
    step("R6 short then overlong",  1, 5, 0, 1, 13, 0, 1);

    step("R9 load before stall",    1, 2, 0, 1, 6, 0, 0);
    step("R9 stall pair waiting",   1, 3, 0, 1, 4, 0, 0);
    step("R9 stall long waiting",   1, 9, 0, 1, 1, 0, 0);
    step("R9 stall vector waiting", 1, 1, 1, 0, 0, 0, 0);
    step("R11 drain and reload",    1, 3, 0, 1, 4, 0, 1);
    step("R11 idle drain",          0, 0, 0, 0, 0, 0, 1);
    step("R11 empty",               0, 0, 0, 0, 0, 0, 1);

    step("R10 load then reset",     1, 10, 0, 1, 1, 0, 0);
    do_reset("R10 mid-flight");
    step("R5 after reset",          1, 2, 0, 1, 2, 0, 1);
    step("R11 final drain",         0, 0, 0, 0, 0, 0, 1);
    step("R11 final idle",          0, 0, 0, 0, 0, 0, 1);
    check("R11 scoreboard empty", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule